// File: doc/BRIEF.md
# S/PDIF Biphase Audio Transmitter

This block takes a three-wire serial audio stream (bit clock, word select, data) and re-emits it as a single biphase-mark coded line in the consumer digital audio subframe layout. The serial front end accepts three framings: left-justified, I2S and right-justified. It extracts 16, 18, 20 or 24-bit words from each channel half and places each word at the MSB end of a 24-bit audio field. When the right word of a pair has been captured, the left/right pair is committed to a holding register.

An encoder runs continuously on `clk`, which is twice the biphase cell rate, so one clock is one half-cell. Every 128 clocks it emits a frame of two 32-slot subframes. A frame latches the most recently committed pair when it starts. Each subframe starts with a preamble that breaks the coding rule. The preamble is followed by audio, validity, user, channel-status and parity slots. The serial pins are oversampled by `clk` through a two-stage synchronizer. Because the serial and output sides are not locked together, a pair can be dropped or repeated when their rates differ.

Top module: `spdif_bmc_tx`

## Requirements
- R1: While `rst_n` is low, `spdif_o` is 0. The first subframe after reset carries the block-start preamble and an all-zero audio field.
- R2: Every data cell (slots 4..31) begins with a transition of `spdif_o`. A cell carrying a one has a second transition at its middle, and a cell carrying a zero has none.
- R3: Preambles are 8 half-cells. Relative to the level before the preamble, their levels are 11101000 (block start), 11100010 (left) and 11100100 (right). The block-start preamble replaces the left preamble in frame 0 of every 192-frame block.
- R4: Slots 4..27 carry the audio field LSB first, slot 28 (validity) is 0 and slot 29 (user) is 0. Slot 30 (channel status) is bit f of `CS_BITS` in frames f = 0..CS_LEN-1 of a block and 0 otherwise. Slot 31 makes the number of ones in slots 4..31 even.
- R5: `ser_data` and `ser_lrck` are sampled on rising edges of `ser_bclk`, with 32 bit clocks per channel half. `ser_lrck` = 0 marks the left half and 1 marks the right half.
- R6: With `fmt_sel` = 0 (left-justified), or the unused value 3, the word MSB is sent in the first bit clock of its half.
- R7: With `fmt_sel` = 1 (I2S), the word MSB is sent one bit clock after `ser_lrck` changes.
- R8: With `fmt_sel` = 2 (right-justified), the word LSB is sent in the last bit clock of its half.
- R9: `width_sel` 0/1/2/3 selects 16/18/20/24-bit words. Each word fills the top of the 24-bit audio field and the unused low bits are 0. Bit clocks outside the word have no effect.
- R10: A committed pair appears, left and right in the same frame, in an output frame that starts at most 128 clocks after the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock (twice the biphase cell rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Serial framing: 0 left-justified, 1 I2S, 2 right-justified, 3 as 0 |
| width_sel | input | 2 | Word width: 0=16, 1=18, 2=20, 3=24 bits |
| ser_bclk | input | 1 | Serial bit clock, sampled by `clk` |
| ser_lrck | input | 1 | Channel select: 0 left, 1 right |
| ser_data | input | 1 | Serial audio data, MSB first |
| spdif_o | output | 1 | Biphase-mark coded output line |

## Verification
The line level for a half-cell is registered, so it shows up one clock after the encoder position that selects it. The bench samples the line on every falling clock edge, locks onto subframes by their three-half-cell preamble run, and checks each subframe's structure as soon as its 64th half-cell arrives. A serial pair is committed about two serial slots after its right half ends (synchronizer plus, for I2S, one extra bit clock). It then reaches a decoded subframe within two output frames (256 clocks). The bench therefore holds each pair for three full serial frames (768 clocks) and compares the last decoded left and right fields only at the end of that window.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int AUD_W = 24;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_ALT = 2'd3
  } ser_fmt_e;

  typedef enum logic [1:0] {
    PRE_BLOCK = 2'd0,
    PRE_LEFT  = 2'd1,
    PRE_RIGHT = 2'd2
  } pre_kind_e;

  typedef struct packed {
    logic [AUD_W-1:0] left;
    logic [AUD_W-1:0] right;
  } pair_t;

  function automatic int unsigned word_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  // Per-half-cell toggle masks, first half-cell in the MSB.
  function automatic logic [7:0] pre_toggles(input pre_kind_e k);
    case (k)
      PRE_BLOCK: return 8'b1001_1100;
      PRE_LEFT:  return 8'b1001_0011;
      default:   return 8'b1001_0110;
    endcase
  endfunction
endpackage

// File: rtl/spdif_ser_deser.sv
module spdif_ser_deser
  import spdif_tx_pkg::*;
#(
  parameter int HALF_SLOTS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fmt_i,
  input  logic [1:0] wsel_i,
  input  logic       bclk_i,
  input  logic       lrck_i,
  input  logic       data_i,
  output pair_t      pair_o
);
  logic [2:0] bclk_q;
  logic [1:0] lrck_q, data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= '0;
      lrck_q <= '0;
      data_q <= '0;
    end else begin
      bclk_q <= {bclk_q[1:0], bclk_i};
      lrck_q <= {lrck_q[0], lrck_i};
      data_q <= {data_q[0], data_i};
    end
  end

  logic rise, lr_now, bit_now;
  assign rise    = bclk_q[1] & ~bclk_q[2];
  assign lr_now  = lrck_q[1];
  assign bit_now = data_q[1];

  logic [HALF_SLOTS-1:0] shreg;
  logic                  lr_prev, i2s_pend, pend_ch;
  logic [AUD_W-1:0]      left_hold;
  logic                  is_i2s, lr_edge, cap, cap_ch;

  assign is_i2s  = (ser_fmt_e'(fmt_i) == FMT_I2S);
  assign lr_edge = rise && (lr_now != lr_prev);
  // I2S words end one bit clock into the next half, so capture one edge later.
  assign cap     = is_i2s ? (rise && i2s_pend) : lr_edge;
  assign cap_ch  = is_i2s ? pend_ch : lr_prev;

  logic [AUD_W-1:0] keep_mask, word_msb;
  int unsigned      wbits;

  always_comb begin
    wbits     = word_bits(wsel_i);
    keep_mask = ~((AUD_W'(1) << (AUD_W - wbits)) - AUD_W'(1));
    if (ser_fmt_e'(fmt_i) == FMT_RJ)
      word_msb = shreg[AUD_W-1:0] << (AUD_W - wbits);
    else
      word_msb = shreg[HALF_SLOTS-1 -: AUD_W] & keep_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      lr_prev   <= 1'b0;
      i2s_pend  <= 1'b0;
      pend_ch   <= 1'b0;
      left_hold <= '0;
      pair_o    <= '0;
    end else begin
      if (rise) begin
        shreg    <= {shreg[HALF_SLOTS-2:0], bit_now};
        lr_prev  <= lr_now;
        i2s_pend <= lr_edge;
        if (lr_edge) pend_ch <= lr_prev;
      end
      if (cap) begin
        if (!cap_ch) left_hold <= word_msb;
        else         pair_o    <= '{left: left_hold, right: word_msb};
      end
    end
  end

  // R5: captures come from separate bit-clock edges, never back to back
  assert_single_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !cap);

  // R9: a 16-bit right word leaves the low byte of the field clear
  assert_low_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && cap_ch && wsel_i == 2'd0) |=> (pair_o.right[7:0] == 8'd0));
endmodule

// File: rtl/spdif_frame_seq.sv
module spdif_frame_seq
  import spdif_tx_pkg::*;
#(
  parameter int                FRAMES  = 192,
  parameter int                CS_LEN  = 8,
  parameter logic [CS_LEN-1:0] CS_BITS = 8'h04
) (
  input  logic  clk,
  input  logic  rst_n,
  input  pair_t pair_i,
  input  logic  line_i,
  output logic  tog_o,
  output logic  cell_start_o
);
  localparam int SUB_SLOTS = 32;
  localparam int SLOT_W    = $clog2(SUB_SLOTS);
  localparam int HC_W      = SLOT_W + 2;
  localparam int FR_W      = $clog2(FRAMES);
  localparam int PRE_SLOTS = 4;
  localparam int AUD_LO    = PRE_SLOTS;
  localparam int VAL_SLOT  = AUD_LO + AUD_W;

  logic [HC_W-1:0]   hc;
  logic [FR_W-1:0]   frame_q;
  pair_t             cur;
  logic              sub_base;
  logic              is_right, half;
  logic [SLOT_W-1:0] slot;

  assign is_right = hc[HC_W-1];
  assign slot     = hc[HC_W-2:1];
  assign half     = hc[0];

  logic [AUD_W-1:0] aud;
  logic             cs_bit, par_bit, dbit;
  pre_kind_e        kind;
  logic [7:0]       pat;

  always_comb begin
    aud    = is_right ? cur.right : cur.left;
    cs_bit = 1'b0;
    for (int i = 0; i < CS_LEN; i++)
      if (frame_q == FR_W'(i)) cs_bit = CS_BITS[i];
    par_bit = (^aud) ^ cs_bit;
    kind    = is_right ? PRE_RIGHT : ((frame_q == '0) ? PRE_BLOCK : PRE_LEFT);
    pat     = pre_toggles(kind);
    if (slot < SLOT_W'(VAL_SLOT))
      dbit = aud[slot - SLOT_W'(AUD_LO)];
    else if (slot == SLOT_W'(VAL_SLOT + 2))
      dbit = cs_bit;
    else if (slot == SLOT_W'(VAL_SLOT + 3))
      dbit = par_bit;
    else
      dbit = 1'b0;
    cell_start_o = (slot >= SLOT_W'(PRE_SLOTS)) && !half;
    if (slot < SLOT_W'(PRE_SLOTS))
      tog_o = pat[3'd7 - {slot[1:0], half}];
    else
      tog_o = half ? dbit : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc       <= '0;
      frame_q  <= '0;
      cur      <= '0;
      sub_base <= 1'b0;
    end else begin
      hc <= hc + 1'b1;
      if (hc == '1)
        frame_q <= (frame_q == FR_W'(FRAMES - 1)) ? '0 : frame_q + 1'b1;
      if (hc == '0) cur <= pair_i;
      if (hc[HC_W-2:0] == '0) sub_base <= line_i;
    end
  end

  // R4: even ones in slots 4..31 return the line to its level at subframe start
  assert_even_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hc[HC_W-2:0] == '0) |-> (line_i == sub_base));

  // R3: every preamble opens with a transition
  assert_preamble_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hc[HC_W-2:0] == '0) |=> (line_i != $past(line_i)));
endmodule

// File: rtl/spdif_bmc_line.sv
module spdif_bmc_line (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_i,
  input  logic cell_start_i,
  output logic line_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_o <= 1'b0;
    else        line_o <= line_o ^ tog_i;
  end

  // R2: each data cell starts with a level change
  assert_cell_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start_i |=> (line_o != $past(line_o)));
endmodule

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx
  import spdif_tx_pkg::*;
#(
  parameter int                HALF_SLOTS = 32,
  parameter int                FRAMES     = 192,
  parameter int                CS_LEN     = 8,
  parameter logic [CS_LEN-1:0] CS_BITS    = 8'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fmt_sel,
  input  logic [1:0] width_sel,
  input  logic       ser_bclk,
  input  logic       ser_lrck,
  input  logic       ser_data,
  output logic       spdif_o
);
  pair_t pair;
  logic  tog, cell_start;

  spdif_ser_deser #(.HALF_SLOTS(HALF_SLOTS)) u_deser (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_sel), .wsel_i(width_sel),
    .bclk_i(ser_bclk), .lrck_i(ser_lrck), .data_i(ser_data), .pair_o(pair)
  );

  spdif_frame_seq #(.FRAMES(FRAMES), .CS_LEN(CS_LEN), .CS_BITS(CS_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .pair_i(pair), .line_i(spdif_o),
    .tog_o(tog), .cell_start_o(cell_start)
  );

  spdif_bmc_line u_line (
    .clk(clk), .rst_n(rst_n), .tog_i(tog), .cell_start_i(cell_start), .line_o(spdif_o)
  );
endmodule

// File: tb/tb_spdif_bmc_tx.sv
module tb_spdif_bmc_tx;
  localparam int         FRAMES = 192;
  localparam logic [7:0] CS_DEF = 8'h04;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [1:0] fmt_sel, width_sel;
  logic       ser_bclk, ser_lrck, ser_data;
  logic       spdif_o;

  spdif_bmc_tx dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .width_sel(width_sel),
    .ser_bclk(ser_bclk), .ser_lrck(ser_lrck), .ser_data(ser_data), .spdif_o(spdif_o)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] w);
    case (w)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  // ---------------- line decoder ----------------
  bit          got_first = 0, exp_right = 0;
  int          exp_frame = 0, n_block = 0;
  logic [23:0] last_l = '0, last_r = '0;
  logic [63:0] sr;
  int          cnt;

  task automatic decode_sf(input logic [63:0] s);
    logic        base, prev, expc;
    logic [7:0]  p;
    logic [27:0] bits;
    int          kind, want;
    bit          cells_ok;
    base = ~s[63];
    p    = s[63:56] ^ {8{base}};
    kind = (p == 8'hE8) ? 0 : (p == 8'hE2) ? 1 : (p == 8'hE4) ? 2 : 3;
    cells_ok = 1;
    prev = s[56];
    for (int k = 0; k < 28; k++) begin
      if (s[55-2*k] == prev) cells_ok = 0;
      bits[k] = s[55-2*k] ^ s[54-2*k];
      prev = s[54-2*k];
    end
    if (!got_first) begin
      chk(kind == 0, "R1", "first preamble", kind, 0);
      chk(bits[23:0] == 24'd0, "R1", "first audio", bits[23:0], 0);
      got_first = 1;
      exp_frame = 0;
      exp_right = 0;
    end
    want = exp_right ? 2 : ((exp_frame == 0) ? 0 : 1);
    chk(kind == want, "R3", "preamble kind", kind, want);
    chk(cells_ok, "R2", "cell transitions", cells_ok, 1);
    chk(bits[25:24] == 2'b00, "R4", "validity/user", bits[25:24], 0);
    expc = (exp_frame < 8) ? CS_DEF[exp_frame[2:0]] : 1'b0;
    chk(bits[26] == expc, "R4", "channel status", bits[26], expc);
    chk(^bits == 1'b0, "R4", "parity", ^bits, 0);
    if (kind == 0) n_block++;
    if (exp_right) begin
      last_r = bits[23:0];
      exp_frame = (exp_frame + 1) % FRAMES;
    end else begin
      last_l = bits[23:0];
    end
    exp_right = ~exp_right;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      sr  = '0;
      cnt = 0;
    end else begin
      sr = {sr[62:0], spdif_o};
      if (cnt == 0) begin
        if (sr[3] != sr[2] && sr[2] == sr[1] && sr[1] == sr[0]) cnt = 3;
      end else begin
        cnt++;
        if (cnt == 64) begin
          decode_sf(sr);
          cnt = 0;
        end
      end
    end
  end

  // ---------------- serial driver ----------------
  logic prev_lsb = 1'b0;

  task automatic send_frame(input logic [1:0] f, input int wb,
                            input logic [23:0] l, input logic [23:0] r);
    for (int h = 0; h < 2; h++) begin
      logic [23:0] word;
      word = h ? r : l;
      for (int s = 0; s < 32; s++) begin
        logic b;
        b = 1'($urandom);
        if (f == 2'd1) begin
          if (s == 0) b = prev_lsb;
          else if (s <= wb) b = word[wb-s];
        end else if (f == 2'd2) begin
          if (s >= 32 - wb) b = word[31-s];
        end else begin
          if (s < wb) b = word[wb-1-s];
        end
        @(negedge clk);
        ser_bclk = 1'b0;
        ser_lrck = 1'(h);
        ser_data = b;
        @(negedge clk);
        @(negedge clk);
        ser_bclk = 1'b1;
        @(negedge clk);
      end
      prev_lsb = word[0];
    end
  endtask

  // ---------------- main ----------------
  initial begin
    void'($urandom(32'h5EED_0A17));
    rst_n = 1'b0; fmt_sel = 2'd0; width_sel = 2'd3;
    ser_bclk = 1'b0; ser_lrck = 1'b0; ser_data = 1'b0;
    repeat (5) @(negedge clk);
    chk(spdif_o == 1'b0, "R1", "line in reset", spdif_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < 48; v++) begin
      logic [1:0]  f, w;
      logic [23:0] l, r, m, el, er;
      int          wb;
      string       tg;
      if (v < 12) begin
        f = 2'(v / 4);
        w = 2'(v % 4);
      end else begin
        f = 2'($urandom_range(0, 3));
        w = 2'($urandom_range(0, 3));
      end
      wb = wbits(w);
      m  = 24'((25'd1 << wb) - 25'd1);
      l  = 24'($urandom) & m;
      r  = 24'($urandom) & m;
      if (v % 4 == 0) begin l = m; r = 24'd0; end                  // full scale vs zero
      if (v % 4 == 1) begin l = 24'd1; r = 24'd1 << (wb - 1); end  // LSB only vs MSB only
      fmt_sel   = f;
      width_sel = w;
      repeat (3) send_frame(f, wb, l, r);
      el = l << (24 - wb);
      er = r << (24 - wb);
      tg = (f == 2'd1) ? "R7" : (f == 2'd2) ? "R8" : "R6";
      chk(last_l == el, $sformatf("%s R5 R9 R10", tg), "left field", last_l, el);
      chk(last_r == er, $sformatf("%s R5 R9 R10", tg), "right field", last_r, er);
    end
    chk(n_block >= 2, "R3", "block starts seen", n_block, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule